// File: doc/BRIEF.md
# LFSR multiplier code converter

This block translates a PLL feedback multiplier between its plain binary value and the scrambled 17-bit code that the PLL's divider register expects. The code is a position on a 15-bit linear feedback shift register orbit, so the conversion is done by stepping that register. The block never uses a lookup table. In the encode direction it also derives the two loop-bandwidth fields from the multiplier and packs them with the code into one 28-bit configuration word. In the decode direction it walks the register backwards to the seed and reports how many steps remained.

Requests enter through a valid/ready port. A request is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole of a conversion. While it is low the port applies back-pressure by ignoring the request: nothing is queued, and the source must hold or re-present it. Each finished conversion raises `done` for one cycle. The result stays on the outputs until the next finished conversion. The parameter `UNROLL` sets how many register steps are taken per clock. It changes latency only, never results.

Top module: `mdec_conv`

## Requirements
- R1: While reset is asserted, and right after it, `in_ready` is 1, `done` is 0, and `out_word` and `out_msel` are 0.
- R2: A request is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is 0 from the cycle after acceptance until `done`. A request presented while `in_ready` is 0 is ignored: it yields no `done` and has no effect on any result.
- R3: `done` is high for exactly one cycle per accepted request. `out_word` and `out_msel` change only in a cycle where `done` is high.
- R4: Encode (`in_decode`=0) maps multiplier 0 to code 0x00000, 1 to 0x18003 and 2 to 0x10003.
- R5: Encode of any other multiplier M starts at state 0x04000 and applies one forward step for each value from M to 32768 inclusive. A forward step makes the new bit 14 equal to bit 0 XOR bit 1 and moves bits 14:1 to bits 13:0. Any M above 32768 therefore yields 0x04000.
- R6: Decode (`in_decode`=1) maps code 0x18003 to 1 and code 0x10003 to 2.
- R7: Decode of any other code loads the whole 17-bit code and a counter of 32769. While the state differs from 0x04000 and the counter is nonzero, it applies one backward step and decrements the counter. A backward step sets the new bit 0 to bit 0 XOR bit 14, moves bits 13:0 to bits 14:1 and clears bits 16:15. The counter is the result, so code 0 yields 0.
- R8: The SELP field is (M >> 1) + 1 for M below 60, otherwise 31.
- R9: The SELI field is 1 for M above 16384, 2 for M above 8192, 4 for M above 2048, and 8 for M from 501 upward. For M from 60 to 500 it is 4 times the ceiling of 1024/(M+9). Below 60 it is (M AND 0x3C) + 4.
- R10: `out_word` carries the code in bits 16:0, SELP in bits 21:17 and SELI in bits 27:22.
- R11: An encode updates only `out_word`, and `out_msel` keeps its value. A decode updates only `out_msel`, and `out_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_decode | input | 1 | 0 = encode multiplier, 1 = decode code |
| in_msel | input | 16 | Binary multiplier for encode |
| in_code | input | 17 | Scrambled code for decode |
| done | output | 1 | One-cycle completion pulse |
| out_word | output | 28 | Packed code and bandwidth fields from the last encode |
| out_msel | output | 16 | Multiplier from the last decode |

## Verification
The hardest situations to reach are the long walks. One is a decode of a code that never reaches the seed, such as zero. Another is a code with bits 16:15 set, which only matter for the first comparison. A third is an encode of a small multiplier, which needs more than 32000 steps. The bench raises `UNROLL` so these finish in about two thousand cycles each, and compares against its own step-by-step model. The ignored request is made by pulsing `in_valid` with a different decode request partway through a long encode. Any extra `done` or a corrupted result then shows up in the scoreboard.

// File: rtl/mdec_conv_pkg.sv
package mdec_conv_pkg;
  localparam int CODE_W = 17;
  localparam int MSEL_W = 16;
  localparam int SELP_W = 5;
  localparam int SELI_W = 6;
  localparam int WORD_W = CODE_W + SELP_W + SELI_W;

  localparam int DIV_NUM_W = 11;
  localparam int DIV_DEN_W = 10;
  localparam int DIV_Q_W   = 5;

  localparam logic [CODE_W-1:0] SEED     = 17'h04000;
  localparam logic [CODE_W-1:0] CODE_ONE = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_TWO = 17'h10003;

  localparam logic [MSEL_W-1:0] MSEL_MAX  = 16'd32768;
  localparam logic [MSEL_W-1:0] DEC_START = 16'd32769;

  localparam logic [MSEL_W-1:0] SELP_LIMIT  = 16'd60;
  localparam logic [SELP_W-1:0] SELP_HIGH   = 5'd31;
  localparam logic [MSEL_W-1:0] SELI_DIV_LO = 16'd60;
  localparam logic [MSEL_W-1:0] SELI_DIV_HI = 16'd500;
  localparam logic [MSEL_W-1:0] SELI_T8     = 16'd501;
  localparam logic [MSEL_W-1:0] SELI_T4     = 16'd2048;
  localparam logic [MSEL_W-1:0] SELI_T2     = 16'd8192;
  localparam logic [MSEL_W-1:0] SELI_T1     = 16'd16384;
  localparam logic [MSEL_W-1:0] SELI_MASK   = 16'h003C;
  localparam logic [DIV_NUM_W-1:0] SELI_NUMER = 11'd1024;
  localparam logic [DIV_DEN_W-1:0] SELI_BIAS  = 10'd9;

  typedef enum logic {DIR_ENC = 1'b0, DIR_DEC = 1'b1} dir_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} phase_e;

  function automatic logic [CODE_W-1:0] fwd_step(input logic [CODE_W-1:0] x);
    return {2'b00, x[0] ^ x[1], x[14:1]};
  endfunction

  function automatic logic [CODE_W-1:0] back_step(input logic [CODE_W-1:0] x);
    return {2'b00, x[13:0], x[0] ^ x[14]};
  endfunction
endpackage

// File: rtl/mdec_lfsr_walk.sv
module mdec_lfsr_walk
  import mdec_conv_pkg::*;
#(
  parameter int UNROLL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  dir_e              mode,
  input  logic [CODE_W-1:0] load_state,
  input  logic [MSEL_W-1:0] load_cnt,
  output logic [CODE_W-1:0] state,
  output logic [MSEL_W-1:0] cnt,
  output logic              fin
);
  logic [CODE_W-1:0] state_q;
  logic [MSEL_W-1:0] cnt_q;
  dir_e              mode_q;

  logic [CODE_W-1:0] s_ch [UNROLL+1];
  logic [MSEL_W-1:0] c_ch [UNROLL+1];
  logic [UNROLL-1:0] take;

  assign s_ch[0] = state_q;
  assign c_ch[0] = cnt_q;

  // One combinational stage per unrolled step; a stage passes through once the walk has ended.
  for (genvar k = 0; k < UNROLL; k++) begin : g_stage
    assign take[k] = (mode_q == DIR_ENC) ? (c_ch[k] != '0)
                                         : ((c_ch[k] != '0) && (s_ch[k] != SEED));
    assign s_ch[k+1] = !take[k]            ? s_ch[k] :
                       (mode_q == DIR_ENC) ? fwd_step(s_ch[k]) : back_step(s_ch[k]);
    assign c_ch[k+1] = take[k] ? (c_ch[k] - MSEL_W'(1)) : c_ch[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      cnt_q   <= '0;
      mode_q  <= DIR_ENC;
    end else if (load) begin
      state_q <= load_state;
      cnt_q   <= load_cnt;
      mode_q  <= mode;
    end else if (run) begin
      state_q <= s_ch[UNROLL];
      cnt_q   <= c_ch[UNROLL];
    end
  end

  assign fin   = (mode_q == DIR_ENC) ? (cnt_q == '0) : ((cnt_q == '0) || (state_q == SEED));
  assign state = state_q;
  assign cnt   = cnt_q;

  // R7: an unfinished walk always consumes count, so it terminates
  p_walk_progress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin && !load) |=> (cnt_q < $past(cnt_q)));

  // R5: encode walks stay inside the 15-bit register
  p_enc_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == DIR_ENC) |=> (state_q[CODE_W-1:15] == 2'b00));
endmodule

// File: rtl/mdec_ceil_div.sv
module mdec_ceil_div
  import mdec_conv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 go,
  input  logic [DIV_NUM_W-1:0] numer,
  input  logic [DIV_DEN_W-1:0] denom,
  output logic [DIV_Q_W-1:0]   quo,
  output logic                 rem_nz,
  output logic                 fin
);
  logic [DIV_NUM_W-1:0] rem_q;
  logic [DIV_DEN_W-1:0] den_q;
  logic [DIV_Q_W-1:0]   quo_q;
  logic                 busy_q;
  logic [DIV_NUM_W-1:0] den_ext;
  logic                 can_sub;

  assign den_ext = {{(DIV_NUM_W-DIV_DEN_W){1'b0}}, den_q};
  assign can_sub = (rem_q >= den_ext);

  // Repeated subtraction: the quotient is small, so one subtract per cycle suffices.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      rem_q  <= numer;
      den_q  <= denom;
      quo_q  <= '0;
      busy_q <= go;
    end else if (busy_q) begin
      if (can_sub) begin
        rem_q <= rem_q - den_ext;
        quo_q <= quo_q + DIV_Q_W'(1);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign quo    = quo_q;
  assign rem_nz = (rem_q != '0);
  assign fin    = !busy_q;

  // R9: a finished division leaves a remainder below the divisor
  p_div_rem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(busy_q) && !$past(load)) |-> (rem_q < den_ext));

  // R9: each subtraction adds exactly one to the quotient
  p_div_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && can_sub && !load) |=> (quo_q == $past(quo_q) + DIV_Q_W'(1)));
endmodule

// File: rtl/mdec_bw_sel.sv
module mdec_bw_sel
  import mdec_conv_pkg::*;
(
  input  logic [MSEL_W-1:0]  msel,
  input  logic [DIV_Q_W-1:0] quo,
  input  logic               rem_nz,
  output logic [SELP_W-1:0]  selp,
  output logic [SELI_W-1:0]  seli
);
  logic [SELI_W-1:0] ceil_part;

  assign ceil_part = SELI_W'({quo, 2'b00}) + (rem_nz ? SELI_W'(4) : SELI_W'(0));

  always_comb begin
    if (msel < SELP_LIMIT) selp = SELP_W'(msel >> 1) + SELP_W'(1);
    else                   selp = SELP_HIGH;
  end

  always_comb begin
    if (msel > SELI_T1)           seli = SELI_W'(1);
    else if (msel > SELI_T2)      seli = SELI_W'(2);
    else if (msel > SELI_T4)      seli = SELI_W'(4);
    else if (msel >= SELI_T8)     seli = SELI_W'(8);
    else if (msel >= SELI_DIV_LO) seli = ceil_part;
    else                          seli = SELI_W'(msel & SELI_MASK) + SELI_W'(4);
  end
endmodule

// File: rtl/mdec_conv.sv
module mdec_conv
  import mdec_conv_pkg::*;
#(
  parameter int UNROLL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_decode,
  input  logic [MSEL_W-1:0] in_msel,
  input  logic [CODE_W-1:0] in_code,
  output logic              done,
  output logic [WORD_W-1:0] out_word,
  output logic [MSEL_W-1:0] out_msel
);
  phase_e            phase_q;
  dir_e              dir_q;
  logic [MSEL_W-1:0] msel_q;
  logic              spec_q;
  logic [CODE_W-1:0] spec_code_q;
  logic [MSEL_W-1:0] spec_msel_q;

  logic              accept, finish;
  logic              enc_spec, dec_spec, div_go;
  logic [CODE_W-1:0] ld_state, enc_spec_code;
  logic [MSEL_W-1:0] ld_cnt, enc_cnt, dec_spec_msel;
  logic [DIV_DEN_W-1:0] div_den;

  logic [CODE_W-1:0]  walk_state;
  logic [MSEL_W-1:0]  walk_cnt;
  logic               walk_fin;
  logic [DIV_Q_W-1:0] div_quo;
  logic               div_rem_nz, div_fin;
  logic [SELP_W-1:0]  selp;
  logic [SELI_W-1:0]  seli;
  logic [CODE_W-1:0]  code_res;
  logic [MSEL_W-1:0]  msel_res;

  assign in_ready = (phase_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  // Load values for a new request
  always_comb begin
    enc_spec = (in_msel <= MSEL_W'(2));
    dec_spec = (in_code == CODE_ONE) || (in_code == CODE_TWO);
    enc_cnt  = (in_msel > MSEL_MAX) ? '0 : (DEC_START - in_msel);
    case (in_msel[1:0])
      2'd1:    enc_spec_code = CODE_ONE;
      2'd2:    enc_spec_code = CODE_TWO;
      default: enc_spec_code = '0;
    endcase
    dec_spec_msel = (in_code == CODE_ONE) ? MSEL_W'(1) : MSEL_W'(2);
    if (in_decode) begin
      ld_state = in_code;
      ld_cnt   = dec_spec ? '0 : DEC_START;
    end else begin
      ld_state = SEED;
      ld_cnt   = enc_spec ? '0 : enc_cnt;
    end
    div_go  = !in_decode && (in_msel >= SELI_DIV_LO) && (in_msel <= SELI_DIV_HI);
    div_den = DIV_DEN_W'(in_msel) + SELI_BIAS;
  end

  mdec_lfsr_walk #(.UNROLL(UNROLL)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .run        (phase_q == ST_RUN),
    .mode       (dir_e'(in_decode)),
    .load_state (ld_state),
    .load_cnt   (ld_cnt),
    .state      (walk_state),
    .cnt        (walk_cnt),
    .fin        (walk_fin)
  );

  mdec_ceil_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .go     (div_go),
    .numer  (SELI_NUMER),
    .denom  (div_den),
    .quo    (div_quo),
    .rem_nz (div_rem_nz),
    .fin    (div_fin)
  );

  mdec_bw_sel u_bw (
    .msel   (msel_q),
    .quo    (div_quo),
    .rem_nz (div_rem_nz),
    .selp   (selp),
    .seli   (seli)
  );

  assign finish   = (phase_q == ST_RUN) && walk_fin && div_fin;
  assign code_res = spec_q ? spec_code_q : walk_state;
  assign msel_res = spec_q ? spec_msel_q : walk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= ST_IDLE;
      dir_q       <= DIR_ENC;
      msel_q      <= '0;
      spec_q      <= 1'b0;
      spec_code_q <= '0;
      spec_msel_q <= '0;
      done        <= 1'b0;
      out_word    <= '0;
      out_msel    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase_q     <= ST_RUN;
        dir_q       <= dir_e'(in_decode);
        msel_q      <= in_msel;
        spec_q      <= in_decode ? dec_spec : enc_spec;
        spec_code_q <= enc_spec_code;
        spec_msel_q <= dec_spec_msel;
      end else if (finish) begin
        phase_q <= ST_IDLE;
        done    <= 1'b1;
        if (dir_q == DIR_ENC) out_word <= {seli, selp, code_res};
        else                  out_msel <= msel_res;
      end
    end
  end

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: results move only together with done
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_word));
  p_msel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_msel));

  // R2: completion follows a busy cycle, never an idle one
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!in_ready));

  // R11: a decode leaves the packed word untouched
  p_dec_keeps_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dir_q == DIR_DEC) |-> $stable(out_word));

  // R4: multiplier 1 encodes to its fixed code
  p_enc_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dir_q == DIR_ENC && msel_q == MSEL_W'(1)) |-> (out_word[CODE_W-1:0] == CODE_ONE));
endmodule

// File: tb/mdec_conv_bench.sv
module mdec_conv_bench;
  import mdec_conv_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic              in_decode;
  logic [MSEL_W-1:0] in_msel;
  logic [CODE_W-1:0] in_code;
  logic              done;
  logic [WORD_W-1:0] out_word;
  logic [MSEL_W-1:0] out_msel;

  mdec_conv #(.UNROLL(16)) u_mdec_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decode(in_decode), .in_msel(in_msel), .in_code(in_code),
    .done(done), .out_word(out_word), .out_msel(out_msel)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit                dec;
    logic [WORD_W-1:0] word;
    logic [MSEL_W-1:0] msel;
    string             req;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [CODE_W-1:0] m_enc(input int m);
    logic [14:0] x;
    if (m == 0) return 17'h00000;
    if (m == 1) return 17'h18003;
    if (m == 2) return 17'h10003;
    x = 15'h4000;
    for (int i = m; i <= 32768; i++) x = {x[0] ^ x[1], x[14:1]};
    return {2'b00, x};
  endfunction

  function automatic logic [SELP_W-1:0] m_selp(input int m);
    return (m < 60) ? SELP_W'((m >> 1) + 1) : SELP_W'(31);
  endfunction

  function automatic logic [SELI_W-1:0] m_seli(input int m);
    if (m > 16384) return 6'd1;
    if (m > 8192)  return 6'd2;
    if (m > 2048)  return 6'd4;
    if (m >= 501)  return 6'd8;
    if (m >= 60)   return SELI_W'(4 * ((1024 + m + 8) / (m + 9)));
    return SELI_W'((m & 32'h3C) + 4);
  endfunction

  function automatic logic [WORD_W-1:0] m_word(input int m);
    return {m_seli(m), m_selp(m), m_enc(m)};
  endfunction

  function automatic logic [MSEL_W-1:0] m_dec(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] x;
    int i;
    if (c == 17'h18003) return 16'd1;
    if (c == 17'h10003) return 16'd2;
    x = c;
    i = 32769;
    while (x != 17'h04000 && i > 0) begin
      x = {2'b00, x[13:0], x[0] ^ x[14]};
      i--;
    end
    return MSEL_W'(i);
  endfunction

  // Driver: wait for ready, present one request for one cycle, push its expectation
  task automatic send(input bit dec, input int m, input logic [CODE_W-1:0] c, input string req);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_decode = dec;
    in_msel   = MSEL_W'(m);
    in_code   = c;
    e.dec  = dec;
    e.word = dec ? '0 : m_word(m);
    e.msel = dec ? m_dec(c) : '0;
    e.req  = req;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", "in_ready after accept", longint'(in_ready), 0);
  endtask

  // Monitor / scoreboard
  logic [WORD_W-1:0] last_word = '0;
  logic [MSEL_W-1:0] last_msel = '0;
  bit prev_done = 1'b0;
  bit moved     = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R3", "done width", longint'(done), 0);
      if (!done && (out_word != last_word || out_msel != last_msel)) moved = 1'b1;
      if (done) begin
        chk(!moved, "R3", "outputs moved without done", longint'(moved), 0);
        moved = 1'b0;
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.dec) begin
            chk(out_msel == e.msel, e.req, "decoded multiplier", longint'(out_msel), longint'(e.msel));
            chk(out_word == last_word, "R11", "word after decode", longint'(out_word), longint'(last_word));
          end else begin
            chk(out_word == e.word, e.req, "packed word", longint'(out_word), longint'(e.word));
            chk(out_msel == last_msel, "R11", "msel after encode", longint'(out_msel), longint'(last_msel));
          end
        end
        last_word = out_word;
        last_msel = out_msel;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R3 watchdog: actual=no completion expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_decode = 1'b0;
    in_msel   = '0;
    in_code   = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_word == '0, "R1", "out_word after reset", longint'(out_word), 0);
    chk(out_msel == '0, "R1", "out_msel after reset", longint'(out_msel), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);

    // R4 fixed small multipliers
    send(1'b0, 0, '0, "R4");
    send(1'b0, 1, '0, "R4");
    send(1'b0, 2, '0, "R4");
    // R6 fixed codes
    send(1'b1, 0, 17'h18003, "R6");
    send(1'b1, 0, 17'h10003, "R6");
    // R5 walks of various lengths, including past the top
    send(1'b0, 32768, '0, "R5");
    send(1'b0, 32767, '0, "R5");
    send(1'b0, 3, '0, "R5");
    send(1'b0, 20000, '0, "R5");
    send(1'b0, 32769, '0, "R5");
    send(1'b0, 65535, '0, "R5");
    // R8 and R10 field placement on low multipliers
    send(1'b0, 59, '0, "R8");
    send(1'b0, 58, '0, "R8");
    send(1'b0, 7, '0, "R10");
    send(1'b0, 40, '0, "R10");
    // R9 band edges and exact-division points
    send(1'b0, 60, '0, "R9");
    send(1'b0, 61, '0, "R9");
    send(1'b0, 119, '0, "R9");
    send(1'b0, 247, '0, "R9");
    send(1'b0, 500, '0, "R9");
    send(1'b0, 501, '0, "R9");
    send(1'b0, 2048, '0, "R9");
    send(1'b0, 2049, '0, "R9");
    send(1'b0, 8192, '0, "R9");
    send(1'b0, 8193, '0, "R9");
    send(1'b0, 16384, '0, "R9");
    send(1'b0, 16385, '0, "R9");
    // R7 backward walks
    send(1'b1, 0, 17'h04000, "R7");
    send(1'b1, 0, 17'h02000, "R7");
    send(1'b1, 0, m_enc(1000), "R7");
    send(1'b1, 0, m_enc(3), "R7");
    send(1'b1, 0, 17'h00000, "R7");
    send(1'b1, 0, 17'h14000, "R7");
    send(1'b1, 0, 17'h1ABCD, "R7");
    send(1'b1, 0, 17'h07FFF, "R7");

    // R2: a request while busy is ignored
    send(1'b0, 32000, '0, "R2");
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R2", "busy during long encode", longint'(in_ready), 0);
    in_valid  = 1'b1;
    in_decode = 1'b1;
    in_code   = 17'h10003;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    send(1'b1, 0, m_enc(32000), "R7");

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule